// File: doc/BRIEF.md
# Video DMA Channel Parameter Register Bank

This block is the software-facing register bank for a pair of video DMA channels: one that reads frames out of memory (the memory-read channel, prefixed `mrd`) and one that writes frames into memory (the memory-write channel, prefixed `mwr`). A host programs each channel over AXI4-Lite. Each channel has a control word with a run bit and three interrupt-enable bits. It also holds a set of video parameters: line count, line length in bytes, line pitch (stride), genlock frame delay and one start address per frame buffer.

Software writes land in a staging copy, and the hardware does not see them. Any order of horizontal-size, stride/delay and address writes is allowed. A write to the vertical-size register commits the staged set. If the channel is running and has not yet started, the commit loads the set straight into the active outputs and fires a one-cycle start pulse. Otherwise the set waits as a single pending copy, and the channel's frame-boundary input moves it into the active outputs. The data mover, genlock and interrupt logic sit outside and consume the active outputs.

AXI4-Lite back-pressure works as follows. A write is taken when address and data are both valid and no write response is outstanding. A read is taken when no read data is outstanding. Responses and read data hold until the host accepts them, so the bank serves one write and one read at a time.

Top module: `vid_dma_csr`

## Requirements
- R1: Every write, mapped or not, gets BRESP=0 (OKAY). Every read gets RRESP=0. BVALID and RVALID, with their data, hold until the matching ready is seen.
- R2: The control word of each channel (offset 0x00 for mrd, 0x30 for mwr) has run in bit 0 and interrupt enables in bits [6:4]. It reads back with all other bits zero and drives the channel's run and irq-enable outputs.
- R3: Writes to horizontal size (+0x04 from the channel parameter base), stride/delay (+0x08) and frame-buffer address words (+0x0C upward) read back the written value. They leave the active outputs unchanged.
- R4: A vertical-size write (+0x00 from the parameter base, which is 0x50 for mrd and 0xA0 for mwr) made while run=1 and the channel is not yet started loads the staged set with the new vertical size into the active outputs. In the cycle after acceptance it raises the start output for exactly one cycle. Later vertical-size writes do not pulse start again.
- R5: A vertical-size write on a started channel, or on a stopped one, stores the set as pending. The active outputs stay unchanged until the channel's frame-boundary input is high on a clock edge, after which they show the pending set.
- R6: When vertical size is committed more than once before a frame boundary, the boundary applies the last committed set.
- R7: A frame boundary with nothing pending leaves the active outputs unchanged, even when the staged values have been modified.
- R8: Writing run=0 stops the channel. A vertical-size write while stopped gives no start pulse. After run is set again, the next vertical-size write pulses start and loads the set.
- R9: Writes to unmapped or unaligned offsets change nothing. Reads of them return zero.
- R10: Field widths are: vertical size 13 bits; horizontal size 16 bits; stride in bits [15:0] and frame delay in bits [28:24] of the stride/delay word. Unused bits read as zero.
- R11: The two channels are independent: a commit, start or frame boundary on one never changes the other's outputs.
- R12: With FB_ADDR_W above 32, each buffer address takes two consecutive words, low 32 bits first. The active address of buffer k sits at bits [k*FB_ADDR_W +: FB_ADDR_W] of the channel's address output.
- R13: Only the byte lanes whose WSTRB bit is set are updated in a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_axi_awaddr | input | AXI_AW | Write byte address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | 32 | Write data |
| s_axi_wstrb | input | 4 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response, always OKAY |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | AXI_AW | Read byte address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | 32 | Read data |
| s_axi_rresp | output | 2 | Read response, always OKAY |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |
| mrd_frame_sync | input | 1 | Frame boundary of the memory-read channel |
| mwr_frame_sync | input | 1 | Frame boundary of the memory-write channel |
| mrd_run | output | 1 | Memory-read channel run bit |
| mrd_irq_en | output | 3 | Memory-read interrupt enables |
| mrd_start | output | 1 | One-cycle start pulse, memory-read |
| mrd_vsize | output | 13 | Active vertical size, memory-read |
| mrd_hsize | output | 16 | Active horizontal size, memory-read |
| mrd_stride | output | 16 | Active stride, memory-read |
| mrd_fdly | output | 5 | Active frame delay, memory-read |
| mrd_fb_addr | output | FB_NUM*FB_ADDR_W | Active buffer addresses, memory-read |
| mwr_run | output | 1 | Memory-write channel run bit |
| mwr_irq_en | output | 3 | Memory-write interrupt enables |
| mwr_start | output | 1 | One-cycle start pulse, memory-write |
| mwr_vsize | output | 13 | Active vertical size, memory-write |
| mwr_hsize | output | 16 | Active horizontal size, memory-write |
| mwr_stride | output | 16 | Active stride, memory-write |
| mwr_fdly | output | 5 | Active frame delay, memory-write |
| mwr_fb_addr | output | FB_NUM*FB_ADDR_W | Active buffer addresses, memory-write |

## Verification
The assertions assume a host that follows AXI4-Lite: it keeps address, data and strobes steady while valid is high and awaits each response before issuing the next access. They also assume word-aligned addresses for mapped registers. Frame-boundary inputs may arrive in any cycle, including the cycle of a commit, and the assertions on pending and active state allow for that overlap. The bench drives one access at a time from tasks that honour these rules. It mixes directed corner cases with a seeded random run of staging writes, commits and boundaries on the memory-read channel. It compares the active outputs with a reference model after every step.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

  localparam int VS_W  = 13;
  localparam int HS_W  = 16;
  localparam int STR_W = 16;
  localparam int DLY_W = 5;
  localparam int DLY_LSB = 24;

  // Parameter word offsets relative to a channel parameter base.
  localparam int OFS_VSIZE  = 0;
  localparam int OFS_HSIZE  = 4;
  localparam int OFS_DLYSTR = 8;
  localparam int OFS_FB0    = 12;

  typedef struct packed {
    logic [VS_W-1:0]  vsize;
    logic [HS_W-1:0]  hsize;
    logic [STR_W-1:0] stride;
    logic [DLY_W-1:0] fdly;
  } vid_set_t;

  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = strb[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pack_dlystr(input vid_set_t s);
    logic [31:0] r;
    r = '0;
    r[STR_W-1:0] = s.stride;
    r[DLY_LSB +: DLY_W] = s.fdly;
    return r;
  endfunction

endpackage

// File: rtl/vdc_axil_port.sv
module vdc_axil_port #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] awaddr,
  input  logic          awvalid,
  output logic          awready,
  input  logic [31:0]   wdata,
  input  logic [3:0]    wstrb,
  input  logic          wvalid,
  output logic          wready,
  output logic [1:0]    bresp,
  output logic          bvalid,
  input  logic          bready,
  input  logic          arvalid,
  output logic          arready,
  output logic [31:0]   rdata,
  output logic [1:0]    rresp,
  output logic          rvalid,
  input  logic          rready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_strb,
  input  logic [31:0]   rd_word
);

  logic rd_take;

  assign awready = wvalid && !bvalid;
  assign wready  = awvalid && !bvalid;
  assign wr_en   = awvalid && wvalid && !bvalid;
  assign wr_addr = awaddr;
  assign wr_data = wdata;
  assign wr_strb = wstrb;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;
  assign arready = !rvalid;
  assign rd_take = arvalid && !rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
    end else if (wr_en) begin
      bvalid <= 1'b1;
    end else if (bready) begin
      bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_take) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid) else $error("bvalid dropped"); // R1
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata)) else $error("rvalid dropped"); // R1
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00) else $error("bad bresp"); // R1

endmodule

// File: rtl/vdc_chan.sv
module vdc_chan
  import vdc_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] CTRL_OFS  = '0,
  parameter logic [AW-1:0] PRM_OFS   = '0,
  parameter int            FB_NUM    = 4,
  parameter int            FB_ADDR_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [3:0]                  wr_strb,
  input  logic [AW-1:0]               rd_addr,
  output logic                        rd_hit,
  output logic [31:0]                 rd_data,
  input  logic                        frame_sync,
  output logic                        run,
  output logic [2:0]                  irq_en,
  output logic                        start_pulse,
  output vid_set_t                    act,
  output logic [FB_NUM*FB_ADDR_W-1:0] act_fb
);

  localparam int WPF    = (FB_ADDR_W + 31) / 32;
  localparam int NWORDS = FB_NUM * WPF;
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int FB_END = OFS_FB0 + 4 * NWORDS;

  typedef struct packed {
    logic          ctrl;
    logic          vs;
    logic          hs;
    logic          ds;
    logic          fb;
    logic [IW-1:0] idx;
  } dec_t;

  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    logic [AW-1:0] off;
    logic [AW-1:0] wi;
    d    = '0;
    off  = a - PRM_OFS;
    wi   = (off - AW'(OFS_FB0)) >> 2;
    d.ctrl = (a == CTRL_OFS);
    if (a >= PRM_OFS && a[1:0] == 2'b00) begin
      d.vs  = (off == AW'(OFS_VSIZE));
      d.hs  = (off == AW'(OFS_HSIZE));
      d.ds  = (off == AW'(OFS_DLYSTR));
      d.fb  = (off >= AW'(OFS_FB0)) && (off < AW'(FB_END));
      d.idx = wi[IW-1:0];
    end
    return d;
  endfunction

  vid_set_t    stg, pnd, nset;
  logic [31:0] stg_addr [NWORDS];
  logic [31:0] pnd_addr [NWORDS];
  logic [31:0] act_addr [NWORDS];
  logic        pend_valid;
  logic        started;
  dec_t        wd, rd;
  logic [31:0] vs_m, hs_m, ds_m, fb_m;
  logic        commit;

  always_comb begin
    wd     = decode(wr_addr);
    rd     = decode(rd_addr);
    vs_m   = byte_merge({{(32-VS_W){1'b0}}, stg.vsize}, wr_data, wr_strb);
    hs_m   = byte_merge({{(32-HS_W){1'b0}}, stg.hsize}, wr_data, wr_strb);
    ds_m   = byte_merge(pack_dlystr(stg), wr_data, wr_strb);
    fb_m   = byte_merge(stg_addr[wd.idx], wr_data, wr_strb);
    nset   = stg;
    nset.vsize = vs_m[VS_W-1:0];
    commit = wr_en && wd.vs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run         <= 1'b0;
      irq_en      <= '0;
      started     <= 1'b0;
      start_pulse <= 1'b0;
      pend_valid  <= 1'b0;
      stg         <= '0;
      pnd         <= '0;
      act         <= '0;
      for (int i = 0; i < NWORDS; i++) begin
        stg_addr[i] <= '0;
        pnd_addr[i] <= '0;
        act_addr[i] <= '0;
      end
    end else begin
      start_pulse <= 1'b0;
      // Frame boundary applies the pending set first; a commit below may refill it.
      if (frame_sync && pend_valid) begin
        act        <= pnd;
        act_addr   <= pnd_addr;
        pend_valid <= 1'b0;
      end
      if (wr_en && wd.ctrl && wr_strb[0]) begin
        run    <= wr_data[0];
        irq_en <= wr_data[6:4];
        if (!wr_data[0]) started <= 1'b0;
      end
      if (wr_en && wd.hs) stg.hsize <= hs_m[HS_W-1:0];
      if (wr_en && wd.ds) begin
        stg.stride <= ds_m[STR_W-1:0];
        stg.fdly   <= ds_m[DLY_LSB +: DLY_W];
      end
      if (wr_en && wd.fb) stg_addr[wd.idx] <= fb_m;
      if (commit) begin
        stg.vsize <= vs_m[VS_W-1:0];
        if (run && !started) begin
          act         <= nset;
          act_addr    <= stg_addr;
          start_pulse <= 1'b1;
          started     <= 1'b1;
          pend_valid  <= 1'b0;
        end else begin
          pnd        <= nset;
          pnd_addr   <= stg_addr;
          pend_valid <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic [32*WPF-1:0] tmp;
    for (int f = 0; f < FB_NUM; f++) begin
      tmp = '0;
      for (int w = 0; w < WPF; w++) tmp[w*32 +: 32] = act_addr[f*WPF + w];
      act_fb[f*FB_ADDR_W +: FB_ADDR_W] = tmp[FB_ADDR_W-1:0];
    end
  end

  always_comb begin
    rd_hit  = rd.ctrl | rd.vs | rd.hs | rd.ds | rd.fb;
    rd_data = '0;
    if (rd.ctrl)    rd_data = {25'b0, irq_en, 3'b0, run};
    else if (rd.vs) rd_data = {{(32-VS_W){1'b0}}, stg.vsize};
    else if (rd.hs) rd_data = {{(32-HS_W){1'b0}}, stg.hsize};
    else if (rd.ds) rd_data = pack_dlystr(stg);
    else if (rd.fb) rd_data = stg_addr[rd.idx];
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse) else $error("start too long"); // R4
  AST_START_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> run && started) else $error("start while stopped"); // R8
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync && !commit |=> $stable(act)) else $error("active changed off boundary"); // R5
  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && pend_valid && !commit |=> !pend_valid && act == $past(pnd)) else $error("pending not applied"); // R5
  AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !pend_valid && !commit |=> $stable(act)) else $error("empty boundary changed active"); // R7
  AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pend_valid || start_pulse) else $error("commit lost"); // R6

endmodule

// File: rtl/vid_dma_csr.sv
module vid_dma_csr
  import vdc_pkg::*;
#(
  parameter int AXI_AW    = 8,
  parameter int FB_NUM    = 4,
  parameter int FB_ADDR_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AXI_AW-1:0]           s_axi_awaddr,
  input  logic                        s_axi_awvalid,
  output logic                        s_axi_awready,
  input  logic [31:0]                 s_axi_wdata,
  input  logic [3:0]                  s_axi_wstrb,
  input  logic                        s_axi_wvalid,
  output logic                        s_axi_wready,
  output logic [1:0]                  s_axi_bresp,
  output logic                        s_axi_bvalid,
  input  logic                        s_axi_bready,
  input  logic [AXI_AW-1:0]           s_axi_araddr,
  input  logic                        s_axi_arvalid,
  output logic                        s_axi_arready,
  output logic [31:0]                 s_axi_rdata,
  output logic [1:0]                  s_axi_rresp,
  output logic                        s_axi_rvalid,
  input  logic                        s_axi_rready,
  input  logic                        mrd_frame_sync,
  input  logic                        mwr_frame_sync,
  output logic                        mrd_run,
  output logic [2:0]                  mrd_irq_en,
  output logic                        mrd_start,
  output logic [VS_W-1:0]             mrd_vsize,
  output logic [HS_W-1:0]             mrd_hsize,
  output logic [STR_W-1:0]            mrd_stride,
  output logic [DLY_W-1:0]            mrd_fdly,
  output logic [FB_NUM*FB_ADDR_W-1:0] mrd_fb_addr,
  output logic                        mwr_run,
  output logic [2:0]                  mwr_irq_en,
  output logic                        mwr_start,
  output logic [VS_W-1:0]             mwr_vsize,
  output logic [HS_W-1:0]             mwr_hsize,
  output logic [STR_W-1:0]            mwr_stride,
  output logic [DLY_W-1:0]            mwr_fdly,
  output logic [FB_NUM*FB_ADDR_W-1:0] mwr_fb_addr
);

  localparam int NCH = 2;

  logic              wr_en;
  logic [AXI_AW-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [3:0]        wr_strb;
  logic [31:0]       rd_word;
  logic [NCH-1:0]    ch_hit;
  logic [31:0]       ch_data [NCH];
  logic [NCH-1:0]    ch_sync, ch_run, ch_start;
  logic [2:0]        ch_irq [NCH];
  vid_set_t          ch_act [NCH];
  logic [FB_NUM*FB_ADDR_W-1:0] ch_fb [NCH];

  vdc_axil_port #(.AW(AXI_AW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_axi_awaddr), .awvalid(s_axi_awvalid), .awready(s_axi_awready),
    .wdata(s_axi_wdata), .wstrb(s_axi_wstrb), .wvalid(s_axi_wvalid), .wready(s_axi_wready),
    .bresp(s_axi_bresp), .bvalid(s_axi_bvalid), .bready(s_axi_bready),
    .arvalid(s_axi_arvalid), .arready(s_axi_arready),
    .rdata(s_axi_rdata), .rresp(s_axi_rresp), .rvalid(s_axi_rvalid), .rready(s_axi_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_word(rd_word)
  );

  assign ch_sync = {mwr_frame_sync, mrd_frame_sync};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AXI_AW-1:0] C_OFS = (g == 0) ? AXI_AW'('h00) : AXI_AW'('h30);
    localparam logic [AXI_AW-1:0] P_OFS = (g == 0) ? AXI_AW'('h50) : AXI_AW'('hA0);
    vdc_chan #(
      .AW(AXI_AW), .CTRL_OFS(C_OFS), .PRM_OFS(P_OFS),
      .FB_NUM(FB_NUM), .FB_ADDR_W(FB_ADDR_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(s_axi_araddr), .rd_hit(ch_hit[g]), .rd_data(ch_data[g]),
      .frame_sync(ch_sync[g]), .run(ch_run[g]), .irq_en(ch_irq[g]),
      .start_pulse(ch_start[g]), .act(ch_act[g]), .act_fb(ch_fb[g])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_hit[c]) rd_word = ch_data[c];
  end

  assign mrd_run     = ch_run[0];
  assign mrd_irq_en  = ch_irq[0];
  assign mrd_start   = ch_start[0];
  assign mrd_vsize   = ch_act[0].vsize;
  assign mrd_hsize   = ch_act[0].hsize;
  assign mrd_stride  = ch_act[0].stride;
  assign mrd_fdly    = ch_act[0].fdly;
  assign mrd_fb_addr = ch_fb[0];
  assign mwr_run     = ch_run[1];
  assign mwr_irq_en  = ch_irq[1];
  assign mwr_start   = ch_start[1];
  assign mwr_vsize   = ch_act[1].vsize;
  assign mwr_hsize   = ch_act[1].hsize;
  assign mwr_stride  = ch_act[1].stride;
  assign mwr_fdly    = ch_act[1].fdly;
  assign mwr_fb_addr = ch_fb[1];

  AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_hit) <= 1) else $error("overlapping decode"); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s_axi_arvalid && s_axi_arready && ch_hit == '0 |=> s_axi_rdata == 32'h0) else $error("unmapped read nonzero"); // R9

endmodule

// File: tb/vid_dma_csr_tb.sv
module vid_dma_csr_tb;

  localparam int FB_NUM = 4;
  localparam int FB_W   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        mrd_sync = 0, mwr_sync = 0;
  logic        mrd_run, mrd_start, mwr_run, mwr_start;
  logic [2:0]  mrd_irq, mwr_irq;
  logic [12:0] mrd_vs, mwr_vs;
  logic [15:0] mrd_hs, mwr_hs, mrd_st, mwr_st;
  logic [4:0]  mrd_fd, mwr_fd;
  logic [FB_NUM*FB_W-1:0] mrd_fb, mwr_fb;

  vid_dma_csr #(.AXI_AW(8), .FB_NUM(FB_NUM), .FB_ADDR_W(FB_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
    .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid), .s_axi_wready(wready),
    .s_axi_bresp(bresp), .s_axi_bvalid(bvalid), .s_axi_bready(bready),
    .s_axi_araddr(araddr), .s_axi_arvalid(arvalid), .s_axi_arready(arready),
    .s_axi_rdata(rdata), .s_axi_rresp(rresp), .s_axi_rvalid(rvalid), .s_axi_rready(rready),
    .mrd_frame_sync(mrd_sync), .mwr_frame_sync(mwr_sync),
    .mrd_run(mrd_run), .mrd_irq_en(mrd_irq), .mrd_start(mrd_start),
    .mrd_vsize(mrd_vs), .mrd_hsize(mrd_hs), .mrd_stride(mrd_st), .mrd_fdly(mrd_fd),
    .mrd_fb_addr(mrd_fb),
    .mwr_run(mwr_run), .mwr_irq_en(mwr_irq), .mwr_start(mwr_start),
    .mwr_vsize(mwr_vs), .mwr_hsize(mwr_hs), .mwr_stride(mwr_st), .mwr_fdly(mwr_fd),
    .mwr_fb_addr(mwr_fb)
  );

  int n_chk = 0, n_fail = 0;
  logic sp_mrd, sp_mwr, b_seen, r_seen;
  logic [1:0] b_resp, r_resp;
  logic [31:0] rd_val;

  task automatic chk(input string req, input logic [63:0] actv, input logic [63:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actv, expv);
    end
  endtask

  task automatic axw(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    b_seen = bvalid; b_resp = bresp; sp_mrd = mrd_start; sp_mwr = mwr_start;
  endtask

  task automatic axr(input logic [7:0] a);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 1;
    @(negedge clk);
    arvalid = 0;
    r_seen = rvalid; r_resp = rresp; rd_val = rdata;
  endtask

  task automatic sync_mrd();
    @(negedge clk); mrd_sync = 1;
    @(negedge clk); mrd_sync = 0;
  endtask

  task automatic sync_mwr();
    @(negedge clk); mwr_sync = 1;
    @(negedge clk); mwr_sync = 0;
  endtask

  function automatic logic [31:0] exp_ds(input logic [31:0] v);
    return v & 32'h1F00FFFF;
  endfunction

  function automatic logic [44:0] pack_set(input logic [12:0] v, input logic [15:0] h,
                                           input logic [31:0] ds);
    return {v, h, ds[15:0]};
  endfunction

  bit done = 0;

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_tb();
    end
  end

  // reference model for the random run on the memory-read channel
  logic [15:0] m_sh; logic [31:0] m_sds;
  logic [12:0] m_pv; logic [15:0] m_ph; logic [31:0] m_pds; logic m_pvld;
  logic [12:0] m_av; logic [15:0] m_ah; logic [31:0] m_ads;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset run", {63'b0, mrd_run}, 0);
    chk("R4 reset vsize", {51'b0, mrd_vs}, 0);
    chk("R4 reset start", {62'b0, mrd_start, mwr_start}, 0);

    axw(8'h00, 32'h71);
    chk("R1 bresp okay", {61'b0, b_seen, b_resp}, {61'b0, 1'b1, 2'b00});
    chk("R2 run/irq out", {60'b0, mrd_irq, mrd_run}, {60'b0, 3'b111, 1'b1});
    axw(8'h00, 32'hFFFFFFFF);
    axr(8'h00);
    chk("R2 ctrl readback", {32'b0, rd_val}, 64'h71);
    chk("R1 rresp okay", {61'b0, r_seen, r_resp}, {61'b0, 1'b1, 2'b00});

    axw(8'h54, 32'h00012345);
    axr(8'h54);
    chk("R10 hsize width", {32'b0, rd_val}, 64'h2345);
    chk("R3 hsize staged only", {48'b0, mrd_hs}, 0);
    axw(8'h58, 32'hFFFFFFFF);
    axr(8'h58);
    chk("R10 dly/stride fields", {32'b0, rd_val}, {32'b0, exp_ds(32'hFFFFFFFF)});
    chk("R3 stride staged only", {48'b0, mrd_st}, 0);
    axw(8'h5C, 32'h00001000);
    axw(8'h60, 32'h0000000A);
    axr(8'h60);
    chk("R3 fb word readback", {32'b0, rd_val}, 64'hA);
    chk("R3 fb not active", mrd_fb[63:0], 0);

    axw(8'h50, 32'hFFFFFFFF);
    chk("R4 start pulse", {63'b0, sp_mrd}, 1);
    chk("R11 other start quiet", {63'b0, sp_mwr}, 0);
    chk("R4 active set loaded", {19'b0, mrd_vs, mrd_hs, mrd_st}, {19'b0, 13'h1FFF, 16'h2345, 16'hFFFF});
    chk("R10 fdly active", {59'b0, mrd_fd}, 64'h1F);
    chk("R12 wide address", mrd_fb[63:0], 64'h0000000A_00001000);
    @(negedge clk);
    chk("R4 start one cycle", {63'b0, mrd_start}, 0);
    axr(8'h50);
    chk("R10 vsize width", {32'b0, rd_val}, 64'h1FFF);

    axw(8'h54, 32'h0800);
    axw(8'h50, 32'h0100);
    chk("R4 no second start", {63'b0, sp_mrd}, 0);
    chk("R5 held before boundary", {35'b0, mrd_vs, mrd_hs}, {35'b0, 13'h1FFF, 16'h2345});
    axw(8'h50, 32'h0200);
    sync_mrd();
    chk("R6 last commit wins", {35'b0, mrd_vs, mrd_hs}, {35'b0, 13'h200, 16'h0800});

    axw(8'h54, 32'h0400);
    sync_mrd();
    chk("R7 empty boundary", {48'b0, mrd_hs}, 64'h0800);

    axw(8'h30, 32'h1);
    axw(8'hA4, 32'h0640);
    axw(8'hA0, 32'h01E0);
    chk("R11 mwr start", {62'b0, sp_mwr, sp_mrd}, 64'b10);
    chk("R11 mwr active", {35'b0, mwr_vs, mwr_hs}, {35'b0, 13'h1E0, 16'h640});
    axw(8'hA4, 32'h0320);
    axw(8'hA0, 32'h00F0);
    sync_mrd();
    chk("R11 other boundary ignored", {48'b0, mwr_hs}, 64'h640);
    sync_mwr();
    chk("R11 own boundary applies", {35'b0, mwr_vs, mwr_hs}, {35'b0, 13'hF0, 16'h320});
    chk("R11 mrd untouched", {48'b0, mrd_hs}, 64'h0800);

    axw(8'h00, 32'h70);
    chk("R8 run cleared", {63'b0, mrd_run}, 0);
    axw(8'h50, 32'h0050);
    chk("R8 no start stopped", {63'b0, sp_mrd}, 0);
    axw(8'h00, 32'h71);
    axw(8'h50, 32'h0060);
    chk("R8 restart pulse", {63'b0, sp_mrd}, 1);
    chk("R8 restart loads", {35'b0, mrd_vs, mrd_hs}, {35'b0, 13'h60, 16'h400});

    axw(8'h7C, 32'hDEAD);
    chk("R1 unmapped bresp", {62'b0, b_resp}, 0);
    axr(8'h7C);
    chk("R9 unmapped read", {32'b0, rd_val}, 0);
    axw(8'h52, 32'h1234);
    axr(8'h50);
    chk("R9 unaligned ignored", {32'b0, rd_val}, 64'h60);
    axr(8'hF0);
    chk("R9 high unmapped read", {32'b0, rd_val}, 0);
    axw(8'h78, 32'hBEEF);
    axr(8'h78);
    chk("R3 last fb word", {32'b0, rd_val}, 64'hBEEF);

    axw(8'h54, 32'h0000AA55, 4'b0001);
    axr(8'h54);
    chk("R13 byte strobe", {32'b0, rd_val}, 64'h0455);

    // random run on the started memory-read channel
    void'($urandom(32'd20240611));
    m_sh = 16'h0455; m_sds = exp_ds(32'hFFFFFFFF);
    m_av = 13'h60; m_ah = 16'h400; m_ads = m_sds; m_pvld = 0;
    m_pv = '0; m_ph = '0; m_pds = '0;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 4);
      v = $urandom;
      case (op)
        0: begin axw(8'h54, v); m_sh = v[15:0]; end
        1: begin axw(8'h58, v); m_sds = exp_ds(v); end
        2: begin
          axw(8'h50, v);
          m_pv = v[12:0]; m_ph = m_sh; m_pds = m_sds; m_pvld = 1;
          chk("R4 random no start", {63'b0, sp_mrd}, 0);
        end
        default: begin
          sync_mrd();
          if (m_pvld) begin m_av = m_pv; m_ah = m_ph; m_ads = m_pds; m_pvld = 0; end
        end
      endcase
      chk("R5 random active", {19'b0, pack_set(mrd_vs, mrd_hs, {16'b0, mrd_st})},
          {19'b0, pack_set(m_av, m_ah, m_ads)});
      chk("R5 random fdly", {59'b0, mrd_fd}, {59'b0, m_ads[28:24]});
    end

    done = 1;
    finish_tb();
  end

endmodule